// File: doc/BRIEF.md
# DDR SDRAM Command Decoder Monitor

This block watches the control pins of a DDR SDRAM bus and, on every rising clock edge, turns the chip-select, row-strobe, column-strobe, write-enable, clock-enable, bank and address bits into a one-hot command. Alongside the command it reports the fields that command carries: row, column, bank, mode op-code, the auto-precharge and all-banks qualifiers, and which mode register a mode load targets. All outputs are registered, so they show the command sampled one edge earlier.

It also keeps a small record of the most recent burst. A burst stop is legal only when that burst was a read without auto precharge. Every other case raises the error strobe. Two other cases also raise it: a command issued with the clock enable low, and a mode load whose bank code names no mode register. Because the clock enable is taken as part of the command, self-refresh entry and auto refresh decode to different outputs.

A testbench or a protocol checker places the block beside a memory controller. It compares the decoded stream against the expected traffic and counts error pulses.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With cs_ni high the command is DESELECT (cmd_o bit 0), every field output is zero and err_o stays low, whatever the other pins and cke_i are.
- R2: With cs_ni low, {ras_ni,cas_ni,we_ni} decodes to a one-hot cmd_o as follows: 111 NOP (bit 1), 011 ACTIVATE (bit 2), 101 READ (bit 3), 100 WRITE (bit 4), 110 BURST STOP (bit 5), 010 PRECHARGE (bit 6), 001 with cke_i high AUTO REFRESH (bit 7), 000 MODE LOAD (bit 9).
- R3: ACTIVATE presents addr_i on row_o and ba_i on bank_o. row_o is zero for every other command.
- R4: READ and WRITE present addr_i[9:0] on col_o and ba_i on bank_o. auto_pre_o equals addr_i[10] for these commands and is zero for all others.
- R5: For PRECHARGE with addr_i[10] high, all_banks_o is 1 and bank_o is 0, whatever ba_i is. With addr_i[10] low, all_banks_o is 0 and bank_o is ba_i.
- R6: MODE LOAD presents addr_i on opcode_o. ext_mode_o is 1 when ba_i is 2'b10 and 0 when ba_i is 2'b00. Any other bank code raises err_o.
- R7: The refresh encoding (001) with cke_i low decodes as SELF REFRESH entry (cmd_o bit 8) without error.
- R8: Any command with cs_ni low other than the refresh encoding, sampled with cke_i low, raises err_o. The command is still decoded normally.
- R9: BURST STOP raises no error when the last READ or WRITE since reset was a READ with addr_i[10] low and no BURST STOP has come since. It raises err_o after a READ with auto precharge, after a WRITE, with no burst since reset, or after an earlier BURST STOP.
- R10: cmd_o, the field outputs and err_o all change on the clock edge after the one that samples the command. err_o is high for exactly the cycle belonging to each offending command.
- R11: While rst_ni is low, cmd_o is DESELECT, all fields and err_o are zero, and the burst record is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | BA_W (2) | Bank address |
| addr_i | input | ADDR_W (13) | Address bus |
| cmd_o | output | 10 | One-hot decoded command |
| bank_o | output | BA_W | Bank of the command, zero when not applicable |
| row_o | output | ADDR_W | Row of an ACTIVATE |
| col_o | output | COL_W (10) | Column of a READ or WRITE |
| opcode_o | output | ADDR_W | Op-code of a MODE LOAD |
| ext_mode_o | output | 1 | MODE LOAD targets the extended mode register |
| auto_pre_o | output | 1 | READ/WRITE with auto precharge |
| all_banks_o | output | 1 | PRECHARGE of all banks |
| err_o | output | 1 | One-cycle illegal-use pulse |

## Verification
The assertions assume that every control, bank and address pin holds a known 0 or 1 at each rising edge and stays settled through it. They also assume a two-bit bank code, so that only 00 and 10 name mode registers. The stimulus changes pins only on the falling edge and never drives X or Z. The bank and address bits are driven with deliberate non-zero junk on commands that ignore them, so that zeroed fields and the all-banks override are visible at the ports. Burst stops are placed after every kind of burst context, including right after reset and after another burst stop. This lets the context-dependent error pulses be checked directly.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  localparam int unsigned NUM_CMD  = 10;
  localparam int unsigned CMD_DESEL = 0;
  localparam int unsigned CMD_NOP   = 1;
  localparam int unsigned CMD_ACT   = 2;
  localparam int unsigned CMD_RD    = 3;
  localparam int unsigned CMD_WR    = 4;
  localparam int unsigned CMD_BST   = 5;
  localparam int unsigned CMD_PRE   = 6;
  localparam int unsigned CMD_AREF  = 7;
  localparam int unsigned CMD_SREF  = 8;
  localparam int unsigned CMD_LMR   = 9;

  typedef logic [NUM_CMD-1:0] cmd_vec_t;

  typedef enum logic [1:0] {
    CTX_NONE    = 2'd0,
    CTX_RD_OPEN = 2'd1,
    CTX_RD_AP   = 2'd2,
    CTX_WR      = 2'd3
  } burst_ctx_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  input  logic     cke_i,
  output cmd_vec_t cmd_oh_o,
  output logic     cke_viol_o
);
  logic [2:0] code;
  assign code = {ras_ni, cas_ni, we_ni};

  always_comb begin
    cmd_oh_o = '0;
    if (cs_ni) begin
      cmd_oh_o[CMD_DESEL] = 1'b1;
    end else begin
      unique case (code)
        3'b111: cmd_oh_o[CMD_NOP] = 1'b1;
        3'b011: cmd_oh_o[CMD_ACT] = 1'b1;
        3'b101: cmd_oh_o[CMD_RD]  = 1'b1;
        3'b100: cmd_oh_o[CMD_WR]  = 1'b1;
        3'b110: cmd_oh_o[CMD_BST] = 1'b1;
        3'b010: cmd_oh_o[CMD_PRE] = 1'b1;
        3'b001: begin
          if (cke_i) cmd_oh_o[CMD_AREF] = 1'b1;
          else       cmd_oh_o[CMD_SREF] = 1'b1;
        end
        default: cmd_oh_o[CMD_LMR] = 1'b1;
      endcase
    end
  end

  // only the refresh encoding may be sampled with clock enable low
  assign cke_viol_o = !cs_ni && !cke_i && (code != 3'b001);
endmodule

// File: rtl/ddr_field_extract.sv
module ddr_field_extract #(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              is_act_i,
  input  logic              is_rd_i,
  input  logic              is_wr_i,
  input  logic              is_pre_i,
  input  logic              is_lmr_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] opcode_o,
  output logic              ext_mode_o,
  output logic              auto_pre_o,
  output logic              all_banks_o,
  output logic              lmr_bad_o
);
  localparam logic [BA_W-1:0] BA_BASE = BA_W'(0);
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(2);

  logic ap_bit;
  logic rw;
  logic bank_used;
  logic [COL_W-1:0] col_raw;

  assign ap_bit = addr_i[AP_BIT];
  assign rw     = is_rd_i | is_wr_i;

  generate
    if (COL_W < ADDR_W) begin : g_col_slice
      assign col_raw = addr_i[COL_W-1:0];
    end else begin : g_col_full
      assign col_raw = COL_W'(addr_i);
    end
  endgenerate

  assign bank_used   = is_act_i | rw | (is_pre_i & !ap_bit);
  assign bank_o      = bank_used ? ba_i : '0;
  assign row_o       = is_act_i ? addr_i : '0;
  assign col_o       = rw ? col_raw : '0;
  assign opcode_o    = is_lmr_i ? addr_i : '0;
  assign ext_mode_o  = is_lmr_i && (ba_i == BA_EXT);
  assign auto_pre_o  = rw & ap_bit;
  assign all_banks_o = is_pre_i & ap_bit;
  assign lmr_bad_o   = is_lmr_i && (ba_i != BA_BASE) && (ba_i != BA_EXT);
endmodule

// File: rtl/ddr_burst_tracker.sv
module ddr_burst_tracker
  import ddr_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic bst_i,
  input  logic ap_i,
  output logic bst_bad_o
);
  burst_ctx_e ctx_q, ctx_d;

  always_comb begin
    ctx_d = ctx_q;
    if (rd_i)       ctx_d = ap_i ? CTX_RD_AP : CTX_RD_OPEN;
    else if (wr_i)  ctx_d = CTX_WR;
    else if (bst_i) ctx_d = CTX_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctx_q <= CTX_NONE;
    else         ctx_q <= ctx_d;
  end

  assign bst_bad_o = bst_i && (ctx_q != CTX_RD_OPEN);

  // R9
  stop_closes_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_i |=> (ctx_q == CTX_NONE));

  // R9
  write_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (ctx_q == CTX_WR));
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              cke_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CMD-1:0] cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] opcode_o,
  output logic              ext_mode_o,
  output logic              auto_pre_o,
  output logic              all_banks_o,
  output logic              err_o
);
  cmd_vec_t          cmd_d;
  logic              cke_viol;
  logic [BA_W-1:0]   bank_d;
  logic [ADDR_W-1:0] row_d;
  logic [COL_W-1:0]  col_d;
  logic [ADDR_W-1:0] opcode_d;
  logic              ext_d, ap_d, ab_d, lmr_bad, bst_bad, err_d;

  ddr_cmd_decode i_decode (
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .cke_i      (cke_i),
    .cmd_oh_o   (cmd_d),
    .cke_viol_o (cke_viol)
  );

  ddr_field_extract #(
    .BA_W   (BA_W),
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) i_fields (
    .is_act_i    (cmd_d[CMD_ACT]),
    .is_rd_i     (cmd_d[CMD_RD]),
    .is_wr_i     (cmd_d[CMD_WR]),
    .is_pre_i    (cmd_d[CMD_PRE]),
    .is_lmr_i    (cmd_d[CMD_LMR]),
    .ba_i        (ba_i),
    .addr_i      (addr_i),
    .bank_o      (bank_d),
    .row_o       (row_d),
    .col_o       (col_d),
    .opcode_o    (opcode_d),
    .ext_mode_o  (ext_d),
    .auto_pre_o  (ap_d),
    .all_banks_o (ab_d),
    .lmr_bad_o   (lmr_bad)
  );

  ddr_burst_tracker i_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (cmd_d[CMD_RD]),
    .wr_i      (cmd_d[CMD_WR]),
    .bst_i     (cmd_d[CMD_BST]),
    .ap_i      (addr_i[AP_BIT]),
    .bst_bad_o (bst_bad)
  );

  assign err_d = cke_viol | lmr_bad | bst_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= NUM_CMD'(1) << CMD_DESEL;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      opcode_o    <= '0;
      ext_mode_o  <= 1'b0;
      auto_pre_o  <= 1'b0;
      all_banks_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      cmd_o       <= cmd_d;
      bank_o      <= bank_d;
      row_o       <= row_d;
      col_o       <= col_d;
      opcode_o    <= opcode_d;
      ext_mode_o  <= ext_d;
      auto_pre_o  <= ap_d;
      all_banks_o <= ab_d;
      err_o       <= err_d;
    end
  end

  // R2
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmd_o) == 1);

  // R1
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o[CMD_DESEL] && !err_o && bank_o == '0));

  // R5
  all_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_banks_o |-> (cmd_o[CMD_PRE] && bank_o == '0));

  // R4
  auto_pre_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |-> (cmd_o[CMD_RD] || cmd_o[CMD_WR]));

  // R8
  cke_low_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !cke_i && !(!ras_ni && !cas_ni && we_ni)) |=> err_o);

  // R7
  self_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !cke_i && !ras_ni && !cas_ni && we_ni) |=> (cmd_o[CMD_SREF] && !err_o));

  // R9
  stop_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_WR] && !cs_ni && ras_ni && cas_ni && !we_ni) |=> err_o);

  // R6
  lmr_bad_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !ras_ni && !cas_ni && !we_ni && ba_i == BA_W'(1)) |=> err_o);
endmodule

// File: tb/test_ddr_cmd_monitor.sv
module test_ddr_cmd_monitor;
  localparam int BA_W = 2;
  localparam int AW   = 13;
  localparam int CW   = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, cke_i = 1'b1;
  logic [BA_W-1:0] ba_i = '0;
  logic [AW-1:0]   addr_i = '0;

  logic [9:0]      cmd_o;
  logic [BA_W-1:0] bank_o;
  logic [AW-1:0]   row_o, opcode_o;
  logic [CW-1:0]   col_o;
  logic ext_mode_o, auto_pre_o, all_banks_o, err_o;

  always #5 clk = ~clk;

  ddr_cmd_monitor i_ddr_cmd_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .cke_i(cke_i), .ba_i(ba_i), .addr_i(addr_i),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .opcode_o(opcode_o), .ext_mode_o(ext_mode_o), .auto_pre_o(auto_pre_o),
    .all_banks_o(all_banks_o), .err_o(err_o)
  );

  typedef struct {
    logic [9:0]      cmd;
    logic [BA_W-1:0] bank;
    logic [AW-1:0]   row;
    logic [CW-1:0]   col;
    logic [AW-1:0]   op;
    logic            ext, ap, ab, err;
    string           req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int ctx = 0; // 0 none, 1 read open, 2 read auto-pre, 3 write
  bit done = 0;

  task automatic send(input logic cs, input logic [2:0] code, input logic cke,
                      input logic [BA_W-1:0] ba, input logic [AW-1:0] addr, input string req);
    exp_t e;
    e.cmd = '0; e.bank = '0; e.row = '0; e.col = '0; e.op = '0;
    e.ext = 0; e.ap = 0; e.ab = 0; e.err = 0; e.req = req;
    @(negedge clk);
    cs_ni = cs; {ras_ni, cas_ni, we_ni} = code; cke_i = cke; ba_i = ba; addr_i = addr;
    if (cs) e.cmd[0] = 1;
    else begin
      if (!cke && code != 3'b001) e.err = 1;
      case (code)
        3'b111: e.cmd[1] = 1;
        3'b011: begin e.cmd[2] = 1; e.row = addr; e.bank = ba; end
        3'b101, 3'b100: begin
          e.cmd[code == 3'b101 ? 3 : 4] = 1;
          e.col = addr[CW-1:0]; e.bank = ba; e.ap = addr[10];
          ctx = (code == 3'b100) ? 3 : (addr[10] ? 2 : 1);
        end
        3'b110: begin e.cmd[5] = 1; if (ctx != 1) e.err = 1; ctx = 0; end
        3'b010: begin e.cmd[6] = 1; e.ab = addr[10]; e.bank = addr[10] ? '0 : ba; end
        3'b001: e.cmd[cke ? 7 : 8] = 1;
        default: begin
          e.cmd[9] = 1; e.op = addr; e.ext = (ba == 2'b10);
          if (ba == 2'b01 || ba == 2'b11) e.err = 1;
        end
      endcase
    end
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (cmd_o !== e.cmd || err_o !== e.err || bank_o !== e.bank || row_o !== e.row ||
            col_o !== e.col || opcode_o !== e.op || ext_mode_o !== e.ext ||
            auto_pre_o !== e.ap || all_banks_o !== e.ab) begin
          errors++;
          $display("FAIL %s cmd %b/%b err %b/%b bank %h/%h row %h/%h col %h/%h op %h/%h ext %b/%b ap %b/%b ab %b/%b",
                   e.req, cmd_o, e.cmd, err_o, e.err, bank_o, e.bank, row_o, e.row,
                   col_o, e.col, opcode_o, e.op, ext_mode_o, e.ext, auto_pre_o, e.ap,
                   all_banks_o, e.ab);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // R11: reset state while held in reset, with busy pins
    cs_ni = 0; {ras_ni, cas_ni, we_ni} = 3'b000; ba_i = 2'b01; addr_i = 13'h1fff;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (cmd_o !== 10'b1 || err_o !== 0 || bank_o !== 0 || row_o !== 0 || col_o !== 0 ||
        opcode_o !== 0 || ext_mode_o || auto_pre_o || all_banks_o) begin
      errors++;
      $display("FAIL R11 cmd %b/%b err %b/0", cmd_o, 10'b1, err_o);
    end
    @(negedge clk);
    cs_ni = 1; rst_ni = 1;

    send(1, 3'b000, 0, 2'b11, 13'h1abc, "R1 deselect junk");
    send(1, 3'b101, 1, 2'b10, 13'h0555, "R1 deselect");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R9 stop after reset");
    send(0, 3'b111, 1, 2'b11, 13'h1fff, "R2 nop");
    send(0, 3'b011, 1, 2'b10, 13'h1234, "R3 activate");
    send(0, 3'b101, 1, 2'b01, 13'h0321, "R4 read no ap");
    send(0, 3'b111, 1, 2'b00, 13'h0000, "R2 nop");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R9 legal stop");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R9 second stop");
    send(0, 3'b101, 1, 2'b11, 13'h07ff, "R4 read ap");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R9 stop after read ap");
    send(0, 3'b100, 1, 2'b10, 13'h00aa, "R4 write");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R9 stop after write");
    send(0, 3'b101, 1, 2'b00, 13'h0001, "R4 read open");
    send(0, 3'b100, 1, 2'b01, 13'h1400, "R4 write ap");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R9 stop after write ap");
    send(0, 3'b010, 1, 2'b11, 13'h0400, "R5 precharge all");
    send(0, 3'b010, 1, 2'b10, 13'h1bff, "R5 precharge one");
    send(0, 3'b000, 1, 2'b00, 13'h0123, "R6 mode base");
    send(0, 3'b000, 1, 2'b10, 13'h1002, "R6 mode ext");
    send(0, 3'b000, 1, 2'b01, 13'h0042, "R6 mode bad 01");
    send(0, 3'b000, 1, 2'b11, 13'h0042, "R6 mode bad 11");
    send(0, 3'b001, 1, 2'b11, 13'h1fff, "R2 auto refresh");
    send(0, 3'b001, 0, 2'b11, 13'h1fff, "R7 self refresh");
    send(1, 3'b000, 0, 2'b00, 13'h0000, "R1 deselect cke low");
    send(0, 3'b011, 0, 2'b01, 13'h0777, "R8 activate cke low");
    send(0, 3'b111, 0, 2'b00, 13'h0000, "R8 nop cke low");
    send(0, 3'b101, 1, 2'b10, 13'h0010, "R10 read");
    send(0, 3'b110, 1, 2'b00, 13'h0000, "R10 stop legal");
    send(0, 3'b111, 1, 2'b00, 13'h0000, "R10 err drops");
    send(1, 3'b111, 1, 2'b00, 13'h0000, "R10 idle");
    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule